// File: doc/BRIEF.md
# Trinomial Field Multiplier, Bit-Parallel

This block multiplies two elements of the binary extension field GF(2^M) in polynomial basis. The field is defined by the trinomial y^M + y^N + 1. Bit i of every operand and of the result is the coefficient of y^i. The work is done in one combinational pass with no iteration, so a new pair of operands can be accepted on every clock. An optional register on the output lets the block sit on a timing boundary.

The datapath has three layers. The first forms every diagonal AND product x_k·z_k and every symmetric cross pair x_a·z_b ⊕ x_b·z_a. The second gathers these into small XOR groups. Each group holds a power-of-two count of AND products, and group h of a low-half or high-half coefficient exists when bit h of that coefficient's product count is set. The third layer forms each output bit as one flat XOR over the groups it needs. The set of groups is chosen by a reduction schedule that covers every middle exponent N from 1 to (M+1)/2. No bracketing is forced on the third layer, so synthesis is free to pack the XOR network.

M, N and the choice of output register are elaboration parameters.

Top module: `gf2m_trinomial_mul`

## Requirements
- R1: p_out equals x_in·z_in reduced modulo y^M + y^N + 1, where bit i of each bus is the coefficient of y^i.
- R2: R1 holds for every N with 1 ≤ N ≤ (M+1)/2. This includes N = 1, N = (M+1)/2 for odd M, and N = M/2 for even M. A setting outside that range, or M < 3, stops elaboration.
- R3: When either operand is zero, the product is zero.
- R4: When one operand equals 1 (only bit 0 set), the product equals the other operand.
- R5: When x_in equals 2 (only bit 1 set), the product is z_in shifted up by one bit. Old bit M−1 is XORed into bits 0 and N.
- R6: Swapping the two operands does not change the product.
- R7: With REG_OUT = 1, p_out shows the product of the operands present at the most recent rising clock edge and holds between edges. With REG_OUT = 0, p_out follows the operands with no clock delay.
- R8: With REG_OUT = 1, driving rst_n low clears p_out to zero at once, without waiting for a clock edge, and p_out stays zero while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| x_in | input | M | First operand, bit i is the coefficient of y^i |
| z_in | input | M | Second operand, same layout |
| p_out | output | M | Reduced product, same layout |

## Verification
The embedded properties assume that both operands carry known values at each rising edge. They also assume the operands do not change within a setup window around that edge. The zero, unit and shift properties only look at operands sampled at the edge, so they rely on the multiplier having settled by then. The bench changes operands only on falling edges and holds them for a full cycle. It also releases reset on a falling edge, so the register-transfer property never sees a half-captured value.

// File: rtl/gfx_pkg.sv
package gfx_pkg;

  // Position of cross pair (a,b), a < b, in the flat pair vector.
  function automatic int pair_idx(int a, int b, int m);
    return a * m - (a * (a + 1)) / 2 + (b - a - 1);
  endfunction

  // Product count of a low-half coefficient (S index) or high-half (T index).
  function automatic int s_count(int si);
    return si;
  endfunction

  function automatic int t_count(int ti, int m);
    return m - 1 - ti;
  endfunction

  // First cross pair (ordinal) that belongs to group h of a coefficient
  // whose product count is cnt; groups fill from the low bit upward.
  function automatic int grp_start(int cnt, int h);
    return (cnt >> 1) & ((1 << (h - 1)) - 1);
  endfunction

  // Does high-half coefficient t feed output bit c?  Schedule for
  // y^m + y^n + 1 with 1 <= n <= (m+1)/2, segmented by output position.
  function automatic bit t_pick(int m, int n, int c, int t);
    int l;
    bit hit;
    l = m - n;
    hit = 1'b0;
    if (c <= n - 2) begin
      hit = (t == c) ^ (t == c + l);
    end else if (c == n - 1) begin
      hit = (t == c);
    end else if (c <= 2 * n - 2) begin
      if ((m % 2 == 0) && (2 * n == m))
        hit = (t == c - n);
      else if (c == m - 1)
        hit = (t == c - n) ^ (t == c - n + l);
      else
        hit = (t == c) ^ (t == c - n) ^ (t == c - n + l);
    end else begin
      hit = (t == c - n);
      if (c <= m - 2) hit = hit ^ (t == c);
    end
    return hit;
  endfunction

endpackage

// File: rtl/gfx_pairs.sv
module gfx_pairs #(
  parameter int M  = 7,
  parameter int NW = M * (M - 1) / 2
) (
  input  logic [M-1:0]  xa,
  input  logic [M-1:0]  za,
  output logic [M-1:0]  vt,
  output logic [NW-1:0] wt
);
  assign vt = xa & za;

  for (genvar a = 0; a < M - 1; a++) begin : g_row
    for (genvar b = a + 1; b < M; b++) begin : g_col
      assign wt[gfx_pkg::pair_idx(a, b, M)] = (xa[a] & za[b]) ^ (xa[b] & za[a]);
    end
  end
endmodule

// File: rtl/gfx_group.sv
module gfx_group #(
  parameter int M  = 7,
  parameter int K  = 2,
  parameter int NW = M * (M - 1) / 2
) (
  input  logic [M-1:0]           vt,
  input  logic [NW-1:0]          wt,
  output logic [M:1][K:0]        s_sub,
  output logic [M-2:0][K:0]      t_sub
);
  // Low half: coefficient of y^(si-1) before reduction.
  for (genvar si = 1; si <= M; si++) begin : g_s
    for (genvar h = 0; h <= K; h++) begin : g_h
      localparam int CNT = gfx_pkg::s_count(si);
      if (((CNT >> h) & 1) == 0) begin : g_off
        assign s_sub[si][h] = 1'b0;
      end else if (h == 0) begin : g_diag
        assign s_sub[si][h] = vt[(si - 1) / 2];
      end else begin : g_tree
        localparam int GS = 1 << (h - 1);
        localparam int ST = gfx_pkg::grp_start(CNT, h);
        logic [GS-1:0] grp;
        for (genvar r = 0; r < GS; r++) begin : g_r
          assign grp[r] = wt[gfx_pkg::pair_idx(ST + r, si - 1 - ST - r, M)];
        end
        assign s_sub[si][h] = ^grp;
      end
    end
  end

  // High half: coefficient of y^(M+ti) before reduction.
  for (genvar ti = 0; ti <= M - 2; ti++) begin : g_t
    for (genvar h = 0; h <= K; h++) begin : g_h
      localparam int CNT = gfx_pkg::t_count(ti, M);
      if (((CNT >> h) & 1) == 0) begin : g_off
        assign t_sub[ti][h] = 1'b0;
      end else if (h == 0) begin : g_diag
        assign t_sub[ti][h] = vt[(M + ti) / 2];
      end else begin : g_tree
        localparam int GS = 1 << (h - 1);
        localparam int ST = gfx_pkg::grp_start(CNT, h);
        logic [GS-1:0] grp;
        for (genvar r = 0; r < GS; r++) begin : g_r
          assign grp[r] = wt[gfx_pkg::pair_idx(ti + 1 + ST + r, M - 1 - ST - r, M)];
        end
        assign t_sub[ti][h] = ^grp;
      end
    end
  end
endmodule

// File: rtl/gfx_fold.sv
module gfx_fold #(
  parameter int M = 7,
  parameter int N = 3,
  parameter int K = 2
) (
  input  logic [M:1][K:0]   s_sub,
  input  logic [M-2:0][K:0] t_sub,
  output logic [M-1:0]      prod
);
  for (genvar c = 0; c < M; c++) begin : g_bit
    logic [M-2:0] tpick;
    for (genvar t = 0; t <= M - 2; t++) begin : g_t
      assign tpick[t] = gfx_pkg::t_pick(M, N, c, t) ? (^t_sub[t]) : 1'b0;
    end
    // One flat reduction per output bit; no forced bracketing.
    assign prod[c] = ^{s_sub[c + 1], tpick};
  end
endmodule

// File: rtl/gf2m_trinomial_mul.sv
module gf2m_trinomial_mul #(
  parameter int M       = 7,
  parameter int N       = 3,
  parameter int REG_OUT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [M-1:0] x_in,
  input  logic [M-1:0] z_in,
  output logic [M-1:0] p_out
);
  localparam int K  = $clog2(M + 1) - 1;
  localparam int NW = M * (M - 1) / 2;
  localparam logic [M-1:0] FOLD_MASK = M'(1) | (M'(1) << N);

  if (M < 3 || N < 1 || 2 * N > M + 1) begin : g_bad_params
    $fatal(1, "gf2m_trinomial_mul: parameters outside 1 <= N <= (M+1)/2, M >= 3");
  end

  logic [M-1:0]        vt;
  logic [NW-1:0]       wt;
  logic [M:1][K:0]     s_sub;
  logic [M-2:0][K:0]   t_sub;
  logic [M-1:0]        prod_c;

  gfx_pairs #(.M(M), .NW(NW)) u_pairs (
    .xa(x_in), .za(z_in), .vt(vt), .wt(wt)
  );

  gfx_group #(.M(M), .K(K), .NW(NW)) u_group (
    .vt(vt), .wt(wt), .s_sub(s_sub), .t_sub(t_sub)
  );

  gfx_fold #(.M(M), .N(N), .K(K)) u_fold (
    .s_sub(s_sub), .t_sub(t_sub), .prod(prod_c)
  );

  // R3
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((x_in == '0) || (z_in == '0)) |-> (prod_c == '0));

  // R4
  unit_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_in == M'(1)) |-> (prod_c == z_in));

  // R5
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_in == M'(2)) |->
      (prod_c == ({z_in[M-2:0], 1'b0} ^ (z_in[M-1] ? FOLD_MASK : '0))));

  if (REG_OUT != 0) begin : g_reg
    logic [M-1:0] prod_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q <= '0;
      else        prod_q <= prod_c;
    end
    assign p_out = prod_q;

    // R7
    reg_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (p_out == $past(prod_c)));
  end else begin : g_comb
    assign p_out = prod_c;
  end
endmodule

// File: tb/gf2m_trinomial_mul_tb_top.sv
module gf2m_trinomial_mul_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCFG = 7;
  localparam int CM [NCFG] = '{7, 7, 8, 9, 11, 15, 10};
  localparam int CN [NCFG] = '{3, 3, 4, 5, 2,  1,  3};
  localparam int CR [NCFG] = '{1, 0, 1, 1, 1,  1,  0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [14:0] x_bus = '1;
  logic [14:0] z_bus = '1;
  logic [14:0] prev_x = '0;
  logic [14:0] prev_z = '0;
  logic [14:0] pout [NCFG];
  logic [31:0] lfsr = 32'h1ace_b00c;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    localparam int GM = CM[g];
    logic [GM-1:0] o;
    gf2m_trinomial_mul #(.M(GM), .N(CN[g]), .REG_OUT(CR[g])) dut_i (
      .clk(clk), .rst_n(rst_n),
      .x_in(x_bus[GM-1:0]), .z_in(z_bus[GM-1:0]), .p_out(o)
    );
    assign pout[g] = 15'(o);
  end

  // Shift-and-add product followed by top-down folding with y^m = y^n + 1.
  function automatic logic [14:0] ref_mul(int m, int n, logic [14:0] a, logic [14:0] b);
    logic [29:0] acc = '0;
    logic [29:0] bm = 30'(b & ((15'(1) << m) - 15'(1)));
    for (int i = 0; i < m; i++)
      if (((a >> i) & 15'(1)) != 15'(0)) acc = acc ^ (bm << i);
    for (int d = 2 * m - 2; d >= m; d--)
      if (((acc >> d) & 30'(1)) != 30'(0))
        acc = acc ^ ((30'(1) << d) | (30'(1) << (d - m)) | (30'(1) << (d - m + n)));
    return acc[14:0];
  endfunction

  function automatic logic [31:0] step(logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic check(int g, logic [14:0] got, logic [14:0] exp, string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s cfg%0d m=%0d n=%0d x=%h z=%h: got %h expected %h",
               tag, g, CM[g], CN[g], x_bus, z_bus, got, exp);
    end
  endtask

  task automatic apply(logic [14:0] xv, logic [14:0] zv, string tag);
    @(negedge clk);
    x_bus = xv;
    z_bus = zv;
    #1;
    for (int g = 0; g < NCFG; g++) begin
      if (CR[g] == 0) check(g, pout[g], ref_mul(CM[g], CN[g], xv, zv), tag);
      else check(g, pout[g], ref_mul(CM[g], CN[g], prev_x, prev_z), "R7 hold");
    end
    @(posedge clk);
    #1;
    for (int g = 0; g < NCFG; g++)
      if (CR[g] != 0) check(g, pout[g], ref_mul(CM[g], CN[g], xv, zv), tag);
    prev_x = xv;
    prev_z = zv;
  endtask

  task automatic check_cleared(string tag);
    for (int g = 0; g < NCFG; g++)
      if (CR[g] != 0) check(g, pout[g], 15'(0), tag);
  endtask

  function automatic logic [14:0] rnd15();
    lfsr = step(lfsr);
    return lfsr[14:0];
  endfunction

  initial begin
    // R8: reset state with nonzero operands applied
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_cleared("R8 reset");
    rst_n = 1'b1;
    prev_x = x_bus;
    prev_z = z_bus;

    // R1: every (7,3) operand pair, upper bits random for the wider fields
    for (int a = 0; a < 128; a++)
      for (int b = 0; b < 128; b++) begin
        logic [14:0] ra = rnd15();
        logic [14:0] rb = rnd15();
        apply({ra[14:7], 7'(a)}, {rb[14:7], 7'(b)}, "R1");
      end

    // R8: asynchronous clear mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_cleared("R8 async");
    @(posedge clk);
    #1;
    check_cleared("R8 held");
    @(negedge clk);
    rst_n = 1'b1;
    prev_x = x_bus;
    prev_z = z_bus;

    // R3, R4, R5 and all-ones corners
    for (int k = 0; k < 40; k++) begin
      logic [14:0] r = rnd15();
      apply(15'(0), r, "R3");
      apply(r, 15'(0), "R3");
      apply(15'(1), r, "R4");
      apply(r, 15'(1), "R4");
      apply(15'(2), r, "R5");
    end
    apply('1, '1, "R1 all-ones");
    apply('1, 15'(1), "R4 all-ones");
    apply(15'(2), '1, "R5 all-ones");

    // R6: swapped operands
    for (int k = 0; k < 200; k++) begin
      logic [14:0] a = rnd15();
      logic [14:0] b = rnd15();
      apply(a, b, "R6");
      apply(b, a, "R6");
    end

    // R2: random pairs across all configurations
    for (int k = 0; k < 2000; k++) apply(rnd15(), rnd15(), "R2");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule